// File: doc/BRIEF.md
# Address Table Search Engine

This block scans a forwarding table for the first entry that satisfies one of four search commands. The commands are: find an address entry by MAC and VLAN ID, find a VLAN entry by VLAN ID, find an unused entry, and find an entry that ageing may reclaim. A single-cycle `start` captures the command and its operands. The engine then issues one table read per cycle, from index 0 upward, through a synchronous read port with one cycle of latency. It evaluates each returned entry as it arrives.

The first entry that satisfies the command ends the search. Running through the whole table without a hit also ends it. Either way, a one-cycle `done` is raised together with `found` and `index`. The engine does not write to the table. A caller that wants to insert an entry uses the result to choose where to write.

Each table entry is 64 bits wide and has these fields:
- bits 63..62: unicast sub-type
- bits 61..60: entry kind
- bits 59..48: VLAN ID
- bits 47..0: MAC address, with the first transmitted byte in bits 47..40 and the last in bits 7..0

Bit 40 is the group (multicast) bit of the address.

Top module: `addr_search_engine`

## Requirements
- R1: With `cmd`=0, an entry is a hit only if its kind is 1 or 3, its bits 59..48 equal `vid_in`, and its bits 47..0 equal `mac_in`. Kinds 0 and 2 never hit, even when their other bits match.
- R2: With `cmd`=1, an entry is a hit only if its kind is 2 and its bits 59..48 equal `vid_in`.
- R3: With `cmd`=2, an entry is a hit if its kind is 0.
- R4: With `cmd`=3, an entry is a hit only if all three hold: its kind is 1 or 3, bit 40 is 0, and its sub-type (bits 63..62) is 1 or 3. Sub-types 0 and 2 never hit.
- R5: Reads are issued at ascending addresses starting from 0, one per cycle. When several entries hit, the reported `index` is the lowest of them.
- R6: When no entry hits, `done` rises with `found`=0 and `index`=DEPTH-1.
- R7: `done` is high for exactly one cycle. If `start` is sampled at clock edge S, `done` rises after edge S+2+i for a hit at index i, and after edge S+DEPTH+1 for a miss. `found` and `index` hold their values until the next `done`.
- R8: A `start` sampled while a search is running, including the edge that raises `done`, has no effect on that search's timing or result.
- R9: After reset, `done`, `found`, `index` and `rd_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a search when the engine is idle |
| cmd | input | 2 | Search command: 0 address, 1 VLAN, 2 free, 3 ageable |
| mac_in | input | 48 | MAC operand for command 0 |
| vid_in | input | 12 | VLAN ID operand for commands 0 and 1 |
| rd_en | output | 1 | Table read strobe |
| rd_addr | output | IDX_W | Table read index |
| rd_data | input | 64 | Entry returned one cycle after the read |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Last search hit |
| index | output | IDX_W | Hit index, or DEPTH-1 on a miss |

## Verification
Two events can coincide and must be told apart:
- a new `start` landing on the same edge that ends a search, which must be ignored;
- a `start` in the cycle where `done` is high, which must begin a fresh search.

The bench provokes both cases by pulsing `start` mid-scan, on the finishing edge, and in the `done` cycle. A behavioural model that counts each search's latency from its accepted start is compared with `done`, `found` and `index` on every cycle. A wrongly accepted start therefore shows up as a shifted or extra `done`.

// File: rtl/ase_pkg.sv
package ase_pkg;

  typedef enum logic [1:0] {
    CMD_ADDR = 2'd0,
    CMD_VLAN = 2'd1,
    CMD_FREE = 2'd2,
    CMD_AGE  = 2'd3
  } search_cmd_e;

  localparam int MAC_W  = 48;
  localparam int VID_W  = 12;
  localparam int GROUP_BIT = 40;

  localparam logic [1:0] KIND_FREE  = 2'd0;
  localparam logic [1:0] KIND_ADDR  = 2'd1;
  localparam logic [1:0] KIND_VLAN  = 2'd2;
  localparam logic [1:0] KIND_VADDR = 2'd3;

  typedef struct packed {
    logic [1:0]       subtype;
    logic [1:0]       kind;
    logic [VID_W-1:0] vid;
    logic [MAC_W-1:0] mac;
  } entry_t;

  localparam int ENTRY_W = $bits(entry_t);

endpackage

// File: rtl/ase_match.sv
module ase_match
  import ase_pkg::*;
(
  input  search_cmd_e      cmd,
  input  logic [MAC_W-1:0] mac,
  input  logic [VID_W-1:0] vid,
  input  entry_t           ent,
  output logic             hit
);

  logic       is_addr;
  logic [3:0] pred;

  assign is_addr = (ent.kind == KIND_ADDR) || (ent.kind == KIND_VADDR);

  generate
    for (genvar c = 0; c < 4; c++) begin : g_pred
      if (c == int'(CMD_ADDR)) begin : g_addr
        assign pred[c] = is_addr && (ent.vid == vid) && (ent.mac == mac);
      end else if (c == int'(CMD_VLAN)) begin : g_vlan
        assign pred[c] = (ent.kind == KIND_VLAN) && (ent.vid == vid);
      end else if (c == int'(CMD_FREE)) begin : g_free
        assign pred[c] = (ent.kind == KIND_FREE);
      end else begin : g_age
        assign pred[c] = is_addr && !ent.mac[GROUP_BIT] && ent.subtype[0];
      end
    end
  endgenerate

  assign hit = pred[cmd];

endmodule

// File: rtl/ase_scan_ctrl.sv
module ase_scan_ctrl #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             finish,
  output logic             busy,
  output logic             issue,
  output logic [IDX_W-1:0] addr,
  output logic             cmp_v,
  output logic [IDX_W-1:0] cmp_idx,
  output logic             cmp_last
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      issue    <= 1'b0;
      addr     <= '0;
      cmp_v    <= 1'b0;
      cmp_idx  <= '0;
      cmp_last <= 1'b0;
    end else if (!busy) begin
      cmp_v <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        issue <= 1'b1;
        addr  <= '0;
      end
    end else if (finish) begin
      busy  <= 1'b0;
      issue <= 1'b0;
      cmp_v <= 1'b0;
    end else begin
      cmp_v <= issue;
      if (issue) begin
        cmp_idx  <= addr;
        cmp_last <= (addr == LAST);
        if (addr == LAST) issue <= 1'b0;
        else              addr  <= addr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/addr_search_engine.sv
module addr_search_engine
  import ase_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          cmd,
  input  logic [MAC_W-1:0]    mac_in,
  input  logic [VID_W-1:0]    vid_in,
  output logic                rd_en,
  output logic [IDX_W-1:0]    rd_addr,
  input  logic [ENTRY_W-1:0]  rd_data,
  output logic                done,
  output logic                found,
  output logic [IDX_W-1:0]    index
);

  search_cmd_e      cmd_q;
  logic [MAC_W-1:0] mac_q;
  logic [VID_W-1:0] vid_q;
  logic             busy, issue, cmp_v, cmp_last, hit, finish;
  logic [IDX_W-1:0] addr, cmp_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= CMD_ADDR;
      mac_q <= '0;
      vid_q <= '0;
    end else if (start && !busy) begin
      cmd_q <= search_cmd_e'(cmd);
      mac_q <= mac_in;
      vid_q <= vid_in;
    end
  end

  ase_scan_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .finish   (finish),
    .busy     (busy),
    .issue    (issue),
    .addr     (addr),
    .cmp_v    (cmp_v),
    .cmp_idx  (cmp_idx),
    .cmp_last (cmp_last)
  );

  ase_match u_match (
    .cmd (cmd_q),
    .mac (mac_q),
    .vid (vid_q),
    .ent (entry_t'(rd_data)),
    .hit (hit)
  );

  assign finish  = cmp_v && (hit || cmp_last);
  assign rd_en   = issue;
  assign rd_addr = addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      done  <= 1'b0;
      found <= 1'b0;
      index <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        found <= hit;
        index <= cmp_idx;
      end
    end
  end

endmodule

// File: rtl/ase_chk.sv
module ase_chk #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             rd_en,
  input logic [IDX_W-1:0] rd_addr,
  input logic             done,
  input logic             found,
  input logic [IDX_W-1:0] index
);

  // R9
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!done && !rd_en));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_en);

  // R5
  first_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_en) |-> (rd_addr == '0));

  // R5
  ascend_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

  // R6
  miss_index_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !found) |-> (index == IDX_W'(DEPTH - 1)));

  // R8
  no_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (start && rd_en) |=> !(rd_en && rd_addr == '0));

endmodule

bind addr_search_engine ase_chk #(.DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .rd_en   (rd_en),
  .rd_addr (rd_addr),
  .done    (done),
  .found   (found),
  .index   (index)
);

// File: tb/tb_addr_search_engine.sv
module tb_addr_search_engine;

  localparam int DEPTH = 64;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] cmd = 2'd0;
  logic [47:0] mac_in = '0;
  logic [11:0] vid_in = '0;
  logic rd_en;
  logic [IDX_W-1:0] rd_addr;
  logic [63:0] rd_data = '0;
  logic done, found;
  logic [IDX_W-1:0] index;

  always #2 clk = ~clk;

  addr_search_engine #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .start(start), .cmd(cmd), .mac_in(mac_in),
    .vid_in(vid_in), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .done(done), .found(found), .index(index)
  );

  logic [63:0] mem [DEPTH];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  string cur_tag = "R9";

  function automatic logic [63:0] mk(input int st, input int kind,
                                     input int vid, input logic [47:0] mac);
    return {2'(st), 2'(kind), 12'(vid), mac};
  endfunction

  function automatic bit pred(input int c, input logic [63:0] e,
                              input logic [47:0] m, input logic [11:0] v);
    int kind = int'(e[61:60]);
    int st   = int'(e[63:62]);
    bit addr_kind = (kind == 1) || (kind == 3);
    case (c)
      0: return addr_kind && e[59:48] == v && e[47:0] == m;
      1: return kind == 2 && e[59:48] == v;
      2: return kind == 0;
      default: return addr_kind && !e[40] && (st == 1 || st == 3);
    endcase
  endfunction

  // behavioural reference
  int m_busy = 0, m_cnt = 0, m_done = 0, m_found = 0, m_idx = 0;
  int r_found = 0, r_idx = 0;
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_cnt = 0; m_done = 0; m_found = 0; m_idx = 0;
    end else begin
      m_done = 0;
      if (m_busy != 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_found = r_found; m_idx = r_idx;
        end
      end else if (start) begin
        r_found = 0; r_idx = DEPTH - 1;
        for (int i = 0; i < DEPTH; i++) begin
          if (r_found == 0 && pred(int'(cmd), mem[i], mac_in, vid_in)) begin
            r_found = 1; r_idx = i;
          end
        end
        m_cnt = (r_found != 0) ? r_idx + 2 : DEPTH + 1;
        m_busy = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      compared++;
      if (int'(done) != m_done) begin
        mismatched++;
        $display("FAIL R7 done: actual %0d expected %0d (cycle %0d)", done, m_done, cyc);
      end else if (int'(found) != m_found || int'(index) != m_idx) begin
        mismatched++;
        $display("FAIL %s found/index: actual %0d/%0d expected %0d/%0d",
                 cur_tag, found, index, m_found, m_idx);
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  task automatic pulse(input int c, input logic [47:0] m, input int v);
    @(negedge clk);
    start = 1'b1; cmd = 2'(c); mac_in = m; vid_in = 12'(v);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (m_done == 0 && n < 200) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic search(input string tag, input int c, input logic [47:0] m, input int v);
    cur_tag = tag;
    pulse(c, m, v);
    wait_done();
    @(negedge clk);
  endtask

  localparam logic [47:0] MAC_A = 48'h02_11_22_33_44_55;
  localparam logic [47:0] MAC_G = 48'h01_00_5E_00_00_07;

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    compared++;
    if (done || found || index != '0 || rd_en) begin
      mismatched++;
      $display("FAIL R9 reset: actual %0b%0b%0d%0b expected 0000", done, found, index, rd_en);
    end

    search("R3", 2, '0, 0);                       // empty table: free at 0
    for (int i = 0; i < DEPTH; i++)
      mem[i] = mk(0, 1, 5, 48'h0A_00_00_00_00_00 | 48'(i));
    search("R3", 2, '0, 0);                       // R6: no free entry
    mem[10] = mk(0, 1, 7, MAC_A);
    mem[20] = mk(0, 3, 7, MAC_A);
    mem[30] = mk(0, 2, 8, MAC_A);
    mem[31] = mk(0, 0, 8, MAC_A);
    search("R5", 0, MAC_A, 7);                    // R1, lowest of two hits
    search("R1", 0, MAC_A, 8);                    // kinds 2 and 0 skipped: miss
    search("R1", 0, MAC_A ^ 48'h1, 7);            // one bit off: miss
    search("R2", 1, '0, 8);                       // VLAN at 30
    search("R6", 1, '0, 99);                      // miss
    search("R3", 2, '0, 0);                       // free at 31
    mem[12] = mk(1, 1, 5, MAC_G);                 // group bit set
    mem[15] = mk(2, 1, 5, MAC_A);                 // sub-type 2
    mem[16] = mk(1, 2, 5, MAC_A);                 // VLAN kind
    mem[17] = mk(3, 3, 5, MAC_A);
    search("R4", 3, '0, 0);                       // ageable at 17
    mem[17] = mk(0, 3, 5, MAC_A);
    mem[50] = mk(1, 1, 5, MAC_A);
    search("R4", 3, '0, 0);                       // ageable at 50
    mem[0] = mk(0, 0, 0, '0);
    search("R7", 2, '0, 0);                       // hit at 0: minimum latency
    mem[0] = mk(0, 1, 5, '0);
    mem[31] = mk(0, 1, 5, '0);
    search("R6", 2, '0, 0);                       // full scan miss

    // R8: start mid-scan and on finishing edge are ignored
    cur_tag = "R8";
    pulse(1, '0, 8);                              // VLAN at 30
    repeat (5) @(negedge clk);
    pulse(2, '0, 0);
    while (m_busy != 0 && m_cnt > 1) @(negedge clk);
    start = 1'b1; cmd = 2'd3;                     // sampled on the done edge
    @(negedge clk);
    start = 1'b0;
    repeat (80) @(negedge clk);

    // R8: start in the done cycle is taken as a new search
    pulse(0, MAC_A, 7);
    wait_done();
    start = 1'b1; cmd = 2'd1; vid_in = 12'd8;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule